// File: doc/BRIEF.md
# SDRAM Clock-Enable and Chip-Select Strobe Shaper

This block sits between a slow host and an SDRAM device that runs on its own, faster clock. The two clocks have no fixed relation. The host writes a three-bit control word into a small register in its own clock domain. The three bits are a clock-enable request level, a chip-select strobe and a one-shot mode bit. The block carries that word into the SDRAM domain as one coherent unit. It then turns each rising host strobe into a pulse exactly one SDRAM clock wide, however long the strobe is held.

There are two modes. With one-shot mode off, the clock-enable output follows the requested level, so the SDRAM clock runs freely. With one-shot mode on, clock-enable rests low and opens for a single SDRAM cycle on each new rising edge of the request. The chip-select output is active low and pulses in both modes. The mode bit passes through one extra delay register before it takes effect. This lines up the moment clock-enable stops being held high with the chip-select pulse that accompanies the same write, so the mode switch never comes before that pulse.

Top module: `sdram_strobe_shaper`

## Requirements
- R1: The host control word (cke level, cs strobe, one-shot bit, each on its own input pin) is loaded only on a host clock rising edge with host_wr_i high. While host_wr_i is low, changes on the three data inputs have no effect on either output.
- R2: A loaded word reaches the SDRAM domain as a whole through a toggle-flag handshake, and the SDRAM-domain capture strobe is never high in two consecutive cycles. Host writes are spaced at least SYNC_STAGES+3 SDRAM cycles apart.
- R3: sdram_cs_n_o rests high. It is low for exactly one SDRAM cycle for each write that changes the cs bit from 0 to 1. A cs bit held at 1 across later writes produces no further pulse.
- R4: With the one-shot bit at 1, sdram_cke_o rests low. It is high for exactly one SDRAM cycle for each write that changes the cke bit from 0 to 1.
- R5: With the one-shot bit at 0, sdram_cke_o equals the most recently written cke bit.
- R6: Consider a write that sets the one-shot bit from 0 to 1 and raises the cs bit from 0 to 1, while clock-enable is held high. sdram_cke_o goes low in the same SDRAM cycle in which sdram_cs_n_o goes low, never earlier.
- R7: A write that clears the one-shot bit returns sdram_cke_o to the written cke level.
- R8: While rst_ni is low, sdram_cke_o is 1 and sdram_cs_n_o is 1. The stored word is cke=1, cs=0 and one-shot=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | SDRAM clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| host_clk_i | input | 1 | Host clock, unrelated to clk_i |
| host_wr_i | input | 1 | Host write strobe for the control word |
| host_cke_i | input | 1 | Requested clock-enable level / one-shot trigger |
| host_cs_i | input | 1 | Chip-select strobe request, active high |
| host_os_i | input | 1 | One-shot mode bit |
| sdram_cke_o | output | 1 | Clock enable to the SDRAM |
| sdram_cs_n_o | output | 1 | Active-low chip select to the SDRAM |

## Verification
Suppose an edge-detect stage failed to update. A held strobe would then show at the pins as a chip-select or clock-enable level stuck active for two or more SDRAM cycles. Such a fault is visible within SYNC_STAGES+4 cycles of the write that exposes it. Suppose instead the mode delay were off by one. The clock-enable fall would then land one cycle before or after the chip-select pulse, and the bench compares the cycle numbers of the two edges directly. If the capture lost coherence, clock-enable would settle to a level that disagrees with the bits written in the same word, and this shows at the check after the write has settled.

// File: rtl/strobe_shaper_pkg.sv
package strobe_shaper_pkg;
  typedef struct packed {
    logic cke;
    logic cs;
    logic os;
  } host_ctrl_t;

  localparam host_ctrl_t CTRL_RST = '{cke: 1'b1, cs: 1'b0, os: 1'b0};
endpackage

// File: rtl/host_ctrl_reg.sv
module host_ctrl_reg
  import strobe_shaper_pkg::*;
(
  input  logic       host_clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  host_ctrl_t d_i,
  output host_ctrl_t q_o,
  output logic       tog_o
);
  host_ctrl_t q;
  logic       tog;

  always_ff @(posedge host_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q   <= CTRL_RST;
      tog <= 1'b0;
    end else if (wr_i) begin
      q   <= d_i;
      tog <= ~tog;
    end
  end

  assign q_o   = q;
  assign tog_o = tog;
endmodule

// File: rtl/ctrl_cdc.sv
module ctrl_cdc
  import strobe_shaper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tog_i,
  input  host_ctrl_t d_i,
  output host_ctrl_t q_o
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] sync_q;
  logic          load;
  host_ctrl_t    cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[LAST-1:0], tog_i};
  end

  // word is stable in the host register once the toggle is seen
  assign load = sync_q[LAST] ^ sync_q[LAST-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cap_q <= CTRL_RST;
    else if (load) cap_q <= d_i;
  end

  assign q_o = cap_q;

  p_load_single_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !load);
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter bit RST_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= RST_LVL;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/sdram_strobe_shaper.sv
module sdram_strobe_shaper
  import strobe_shaper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_clk_i,
  input  logic host_wr_i,
  input  logic host_cke_i,
  input  logic host_cs_i,
  input  logic host_os_i,
  output logic sdram_cke_o,
  output logic sdram_cs_n_o
);
  host_ctrl_t host_d, host_q, cap, cap_q;
  logic       host_tog;
  logic       cs_rise, cke_rise;
  logic       cke_q, cs_n_q;

  assign host_d = '{cke: host_cke_i, cs: host_cs_i, os: host_os_i};

  host_ctrl_reg u_host_reg (
    .host_clk_i(host_clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (host_wr_i),
    .d_i       (host_d),
    .q_o       (host_q),
    .tog_o     (host_tog)
  );

  ctrl_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tog_i (host_tog),
    .d_i   (host_q),
    .q_o   (cap)
  );

  // delay stage: cap_q.os is the delayed one-shot enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= CTRL_RST;
    else         cap_q <= cap;
  end

  strobe_edge #(.RST_LVL(CTRL_RST.cs)) u_cs_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (cap_q.cs),
    .rise_o(cs_rise)
  );

  strobe_edge #(.RST_LVL(CTRL_RST.cke)) u_cke_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (cap_q.cke),
    .rise_o(cke_rise)
  );

  // one-shot logic held cleared (free-run level) until delayed enable is set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= 1'b1;
      cs_n_q <= 1'b1;
    end else begin
      cke_q  <= cap_q.os ? cke_rise : cap_q.cke;
      cs_n_q <= ~cs_rise;
    end
  end

  assign sdram_cke_o  = cke_q;
  assign sdram_cs_n_o = cs_n_q;

  p_cs_single_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdram_cs_n_o |=> sdram_cs_n_o);

  p_cke_single_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q.os && $past(cap_q.os) && sdram_cke_o) |=> !sdram_cke_o);

  p_mode_align_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && cap_q.os && !cke_rise) |=> (!sdram_cs_n_o && !sdram_cke_o));
endmodule

// File: tb/sdram_strobe_shaper_test.sv
`timescale 1ns/1ps
module sdram_strobe_shaper_test;
  logic clk = 1'b0, host_clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, h_cke = 1'b1, h_cs = 1'b0, h_os = 1'b0;
  logic cke, cs_n;

  int vectors = 0, errs = 0;
  int cyc = 0;
  bit prev_cke = 1'b1, prev_cs_n = 1'b1;
  int cs_wide = 0;
  int w_cs_falls, w_cke_rises, w_cke_hh, w_cs_fall_cyc, w_cke_fall_cyc;
  bit p_cke = 1'b1, p_cs = 1'b0, p_os = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always #18.65 host_clk = ~host_clk;

  sdram_strobe_shaper uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .host_clk_i  (host_clk),
    .host_wr_i   (wr),
    .host_cke_i  (h_cke),
    .host_cs_i   (h_cs),
    .host_os_i   (h_os),
    .sdram_cke_o (cke),
    .sdram_cs_n_o(cs_n)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!cs_n) begin
        if (!prev_cs_n) cs_wide++;
        else begin
          w_cs_falls++;
          if (w_cs_fall_cyc < 0) w_cs_fall_cyc = cyc;
        end
      end
      if (cke && !prev_cke) w_cke_rises++;
      if (cke && prev_cke)  w_cke_hh++;
      if (!cke && prev_cke && w_cke_fall_cyc < 0) w_cke_fall_cyc = cyc;
      prev_cke  = cke;
      prev_cs_n = cs_n;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic open_window();
    w_cs_falls = 0; w_cke_rises = 0; w_cke_hh = 0;
    w_cs_fall_cyc = -1; w_cke_fall_cyc = -1;
  endtask

  task automatic settle();
    repeat (14) @(posedge clk);
    #5;
  endtask

  function automatic int exp_cke(bit k, bit o);
    return o ? 0 : int'(k);
  endfunction

  task automatic do_write(bit n_cke, bit n_cs, bit n_os);
    @(negedge host_clk);
    open_window();
    h_cke = n_cke; h_cs = n_cs; h_os = n_os; wr = 1'b1;
    @(negedge host_clk);
    wr = 1'b0;
    // junk on data pins without a write (R1)
    h_cke = 1'($urandom); h_cs = 1'($urandom); h_os = 1'($urandom);
    settle();
    chk("R3 cs pulse count", w_cs_falls, int'(n_cs && !p_cs));
    chk(n_os ? "R4 cke rest level" : (p_os ? "R7 cke after exit" : "R5 cke level"),
        int'(cke), exp_cke(n_cke, n_os));
    if (p_os && n_os) begin
      chk("R4 cke pulse count", w_cke_rises, int'(n_cke && !p_cke));
      chk("R4 cke pulse width", w_cke_hh, 0);
    end
    if (!p_os && !n_os)
      chk("R5 cke edges", w_cke_rises, int'(n_cke && !p_cke));
    if (!p_os && n_os && p_cke && n_cs && !p_cs) begin
      chk("R6 cke fall vs cs fall cycle", w_cke_fall_cyc, w_cs_fall_cyc);
      chk("R6 cke fall seen", int'(w_cke_fall_cyc >= 0), 1);
    end
    p_cke = n_cke; p_cs = n_cs; p_os = n_os;
  endtask

  task automatic idle_check();
    @(negedge host_clk);
    open_window();
    repeat (3) begin
      @(negedge host_clk);
      h_cke = ~h_cke; h_cs = ~h_cs; h_os = ~h_os;
    end
    settle();
    chk("R1 no pulse without write", w_cs_falls, 0);
    chk("R1 cke unchanged without write", int'(cke), exp_cke(p_cke, p_os));
  endtask

  initial begin
    void'($urandom(32'd1234));
    open_window();
    repeat (3) @(posedge clk);
    #5;
    chk("R8 cke in reset", int'(cke), 1);
    chk("R8 cs_n in reset", int'(cs_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R8 cke after reset", int'(cke), 1);
    chk("R8 cs_n after reset", int'(cs_n), 1);
    // directed
    do_write(1, 1, 0);
    do_write(1, 1, 0);   // held strobe, no second pulse (R3)
    do_write(1, 0, 0);
    do_write(1, 1, 1);   // mode entry aligned (R6)
    do_write(1, 0, 1);
    do_write(0, 0, 1);
    do_write(1, 0, 1);   // one-shot pulse (R4)
    do_write(1, 1, 1);
    do_write(1, 0, 0);   // exit (R7)
    do_write(0, 0, 0);
    idle_check();
    do_write(1, 0, 0);
    // random
    for (int i = 0; i < 120; i++) begin
      if (($urandom % 8) == 0) idle_check();
      else do_write(1'($urandom), 1'($urandom), 1'($urandom));
    end
    chk("R3 cs_n never low two cycles", cs_wide, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      vectors++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule